// File: doc/BRIEF.md
# Half-Duplex Carrier Sense Monitor

This block watches the carrier sense input of a MAC transmitter in half-duplex mode while a frame is going out. It tells apart two faults. In the first, carrier never shows up at all during the frame. In the second, carrier was present and then went away before the frame finished. When carrier is lost, the block sends a one-cycle abort request to the transmitter. When the frame ends, it reports a status word.

The carrier sense input is asynchronous, so it first passes through a synchronizer before the block uses it. Monitoring is active only when both of these hold: the link is in half-duplex mode, and the ignore control is clear. If either condition fails, the block reports nothing and requests no abort. The ignore control resets to 0 in the surrounding logic, so checking is active by default.

The block is built around a state machine with five states:
- `ST_IDLE`: no frame is in progress.
- `ST_WAIT_CRS`: a frame is in progress and carrier has not been seen yet.
- `ST_CARRIER`: carrier has been seen.
- `ST_LOST`: carrier dropped after it had been seen.
- `ST_BYPASS`: a frame is in progress with monitoring off.

Transitions:
- `ST_IDLE` moves when transmit goes active. It goes to `ST_BYPASS` if monitoring is off, to `ST_CARRIER` if carrier is present, and to `ST_WAIT_CRS` otherwise.
- `ST_WAIT_CRS` moves to `ST_CARRIER` when carrier appears.
- `ST_CARRIER` moves to `ST_LOST` when carrier drops. This transition also raises the abort pulse.
- `ST_WAIT_CRS`, `ST_CARRIER` and `ST_LOST` all move to `ST_BYPASS` if monitoring turns off during the frame.
- Every non-idle state returns to `ST_IDLE` when transmit goes inactive. This return raises the status report.

Top module: `hd_crs_monitor`

## Requirements
- R1: After reset, all outputs (`status_valid_o`, `no_carrier_o`, `carrier_lost_o`, `abort_o`) are 0.
- R2: Carrier sense passes through two synchronizer flops. A drop of `crs_async_i` driven before rising edge k produces `abort_o` high after edge k+2, and not earlier.
- R3: `status_valid_o` is a one-cycle pulse that goes high after the first rising edge where `tx_active_i` is sampled low while a frame is in progress. In that report, `no_carrier_o`=1 if synchronized carrier was never high during a monitored frame.
- R4: In the report, `carrier_lost_o`=1 if carrier was seen high and then dropped before transmit ended. This holds even if carrier came back later.
- R5: `abort_o` is a single-cycle pulse issued only on the first loss of carrier in a frame. Later drops in the same frame issue no further pulse.
- R6: A monitored frame during which carrier stays present, or appears late and stays, reports both flags as 0 and issues no abort.
- R7: While `crs_ignore_i`=1, carrier sense is ignored. There is no abort, and both flags in the report are 0. This also applies when the control is set partway through a frame.
- R8: While `half_duplex_i`=0, the block has no effect. There is no abort, and both flags in the report are 0.
- R9: The flags keep their value until the next report. `no_carrier_o` and `carrier_lost_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active_i | input | 1 | High while a frame is being sent |
| half_duplex_i | input | 1 | 1 = half-duplex, 0 = full-duplex |
| crs_async_i | input | 1 | Carrier sense, asynchronous |
| crs_ignore_i | input | 1 | 1 = ignore carrier sense |
| status_valid_o | output | 1 | One-cycle pulse at end of frame |
| no_carrier_o | output | 1 | Carrier never seen in the last frame |
| carrier_lost_o | output | 1 | Carrier dropped in the last frame |
| abort_o | output | 1 | One-cycle abort request to the transmitter |

## Verification
A wrong internal state shows up at the ports by the end of the frame. If the machine is stuck in `ST_WAIT_CRS` or misses the move to `ST_LOST`, the status word that follows `tx_active_i` falling has the wrong flags. A wrong entry into `ST_LOST` shows within one cycle as an extra or missing `abort_o` pulse. Because the synchronizer sets a fixed three-edge latency, an abort arriving one cycle early or late points to a fault in the synchronizer rather than in the state machine. A machine that fails to reach `ST_BYPASS` produces flags or aborts in frames where the ignore control is set or full-duplex mode is selected.

// File: rtl/crsmon_pkg.sv
package crsmon_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_CRS = 3'd1,
        ST_CARRIER  = 3'd2,
        ST_LOST     = 3'd3,
        ST_BYPASS   = 3'd4
    } crs_state_t;
endpackage

// File: rtl/crsmon_sync.sv
module crsmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/crsmon_fsm.sv
module crsmon_fsm
    import crsmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active_i,
    input  logic monitor_on_i,
    input  logic crs_i,
    output logic status_valid_o,
    output logic no_carrier_o,
    output logic carrier_lost_o,
    output logic abort_o
);
    crs_state_t state_q, state_d;
    logic       frame_end;
    logic       loss_evt;

    assign frame_end = (state_q != ST_IDLE) && !tx_active_i;
    assign loss_evt  = (state_q == ST_CARRIER) && tx_active_i && monitor_on_i && !crs_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_active_i) begin
                    if (!monitor_on_i) state_d = ST_BYPASS;
                    else if (crs_i)    state_d = ST_CARRIER;
                    else               state_d = ST_WAIT_CRS;
                end
            end
            ST_WAIT_CRS: begin
                if (!tx_active_i)       state_d = ST_IDLE;
                else if (!monitor_on_i) state_d = ST_BYPASS;
                else if (crs_i)         state_d = ST_CARRIER;
            end
            ST_CARRIER: begin
                if (!tx_active_i)       state_d = ST_IDLE;
                else if (!monitor_on_i) state_d = ST_BYPASS;
                else if (!crs_i)        state_d = ST_LOST;
            end
            ST_LOST: begin
                if (!tx_active_i)       state_d = ST_IDLE;
                else if (!monitor_on_i) state_d = ST_BYPASS;
            end
            ST_BYPASS: begin
                if (!tx_active_i)       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_valid_o <= 1'b0;
            no_carrier_o   <= 1'b0;
            carrier_lost_o <= 1'b0;
            abort_o        <= 1'b0;
        end else begin
            status_valid_o <= frame_end;
            abort_o        <= loss_evt;
            if (frame_end) begin
                no_carrier_o   <= monitor_on_i && (state_q == ST_WAIT_CRS);
                carrier_lost_o <= monitor_on_i && (state_q == ST_LOST);
            end
        end
    end
endmodule

// File: rtl/hd_crs_monitor.sv
module hd_crs_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active_i,
    input  logic half_duplex_i,
    input  logic crs_async_i,
    input  logic crs_ignore_i,
    output logic status_valid_o,
    output logic no_carrier_o,
    output logic carrier_lost_o,
    output logic abort_o
);
    logic crs_sync;
    logic monitor_on;

    assign monitor_on = half_duplex_i && !crs_ignore_i;

    crsmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (crs_async_i),
        .q_o   (crs_sync)
    );

    crsmon_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_active_i    (tx_active_i),
        .monitor_on_i   (monitor_on),
        .crs_i          (crs_sync),
        .status_valid_o (status_valid_o),
        .no_carrier_o   (no_carrier_o),
        .carrier_lost_o (carrier_lost_o),
        .abort_o        (abort_o)
    );
endmodule

// File: rtl/crsmon_checker.sv
module crsmon_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_active_i,
    input logic half_duplex_i,
    input logic crs_ignore_i,
    input logic status_valid_o,
    input logic no_carrier_o,
    input logic carrier_lost_o,
    input logic abort_o
);
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);                                                        // R5
    AST_ABORT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(tx_active_i));                                              // R5
    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid_o |=> !status_valid_o);                                          // R3
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(no_carrier_o && carrier_lost_o));                                           // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !status_valid_o |-> ($stable(no_carrier_o) && $stable(carrier_lost_o)));     // R9
    AST_IGNORE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(crs_ignore_i) |-> !abort_o);                                            // R7
    AST_IGNORE_CLEAN_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid_o && $past(crs_ignore_i)) |-> (!no_carrier_o && !carrier_lost_o)); // R7
    AST_FULL_DUPLEX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(half_duplex_i) |-> (!abort_o && !(status_valid_o && (no_carrier_o || carrier_lost_o)))); // R8
endmodule

bind hd_crs_monitor crsmon_checker u_crsmon_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_active_i    (tx_active_i),
    .half_duplex_i  (half_duplex_i),
    .crs_ignore_i   (crs_ignore_i),
    .status_valid_o (status_valid_o),
    .no_carrier_o   (no_carrier_o),
    .carrier_lost_o (carrier_lost_o),
    .abort_o        (abort_o)
);

// File: tb/test_hd_crs_monitor.sv
module test_hd_crs_monitor;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_active_i = 1'b0;
    logic half_duplex_i = 1'b1;
    logic crs_async_i = 1'b0;
    logic crs_ignore_i = 1'b0;
    logic status_valid_o, no_carrier_o, carrier_lost_o, abort_o;

    int total = 0;
    int bad = 0;
    int abort_cnt = 0;
    bit done = 1'b0;

    hd_crs_monitor i_hd_crs_monitor (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_active_i    (tx_active_i),
        .half_duplex_i  (half_duplex_i),
        .crs_async_i    (crs_async_i),
        .crs_ignore_i   (crs_ignore_i),
        .status_valid_o (status_valid_o),
        .no_carrier_o   (no_carrier_o),
        .carrier_lost_o (carrier_lost_o),
        .abort_o        (abort_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (abort_o) abort_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_frame(input string req, input int exp_nc, input int exp_lost);
        tx_active_i = 1'b0;
        cyc(1);
        chk({req, " status_valid"}, status_valid_o, 1);
        chk({req, " no_carrier"}, no_carrier_o, exp_nc);
        chk({req, " carrier_lost"}, carrier_lost_o, exp_lost);
        cyc(1);
        chk({req, " status pulse ends"}, status_valid_o, 0);
        cyc(2);
    endtask

    task automatic t_reset;
        cyc(3);
        chk("R1 status_valid", status_valid_o, 0);
        chk("R1 no_carrier", no_carrier_o, 0);
        chk("R1 carrier_lost", carrier_lost_o, 0);
        chk("R1 abort", abort_o, 0);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic t_no_carrier;
        crs_async_i = 1'b0; cyc(3);
        abort_cnt = 0;
        tx_active_i = 1'b1; cyc(6);
        end_frame("R3", 1, 0);
        chk("R3 no abort", abort_cnt, 0);
        chk("R9 no_carrier held", no_carrier_o, 1);
    endtask

    task automatic t_clean;
        crs_async_i = 1'b1; cyc(3);
        abort_cnt = 0;
        tx_active_i = 1'b1; cyc(8);
        end_frame("R6 steady", 0, 0);
        chk("R6 steady no abort", abort_cnt, 0);
        crs_async_i = 1'b0; cyc(3);
        tx_active_i = 1'b1; cyc(3);
        crs_async_i = 1'b1; cyc(6);
        end_frame("R6 late carrier", 0, 0);
        chk("R6 late no abort", abort_cnt, 0);
    endtask

    task automatic t_loss;
        crs_async_i = 1'b1; cyc(3);
        abort_cnt = 0;
        tx_active_i = 1'b1; cyc(4);
        crs_async_i = 1'b0;
        cyc(1); chk("R2 abort edge+1", abort_o, 0);
        cyc(1); chk("R2 abort edge+2 early", abort_o, 0);
        cyc(1); chk("R2 abort after third edge", abort_o, 1);
        cyc(1); chk("R5 abort one cycle", abort_o, 0);
        crs_async_i = 1'b1; cyc(5);
        crs_async_i = 1'b0; cyc(5);
        chk("R5 single abort per frame", abort_cnt, 1);
        crs_async_i = 1'b1; cyc(4);
        end_frame("R4", 0, 1);
        chk("R9 carrier_lost held", carrier_lost_o, 1);
    endtask

    task automatic t_disable;
        crs_ignore_i = 1'b1;
        crs_async_i = 1'b0; cyc(3);
        abort_cnt = 0;
        tx_active_i = 1'b1; cyc(5);
        end_frame("R7 no carrier ignored", 0, 0);
        crs_async_i = 1'b1; cyc(3);
        tx_active_i = 1'b1; cyc(4);
        crs_async_i = 1'b0; cyc(6);
        end_frame("R7 drop ignored", 0, 0);
        chk("R7 no abort", abort_cnt, 0);
        crs_ignore_i = 1'b0;
        crs_async_i = 1'b0; cyc(3);
        tx_active_i = 1'b1; cyc(3);
        crs_ignore_i = 1'b1; cyc(3);
        end_frame("R7 set mid-frame", 0, 0);
        crs_ignore_i = 1'b0;
    endtask

    task automatic t_full_duplex;
        half_duplex_i = 1'b0;
        crs_async_i = 1'b1; cyc(3);
        abort_cnt = 0;
        tx_active_i = 1'b1; cyc(4);
        crs_async_i = 1'b0; cyc(6);
        end_frame("R8 drop", 0, 0);
        tx_active_i = 1'b1; cyc(5);
        end_frame("R8 no carrier", 0, 0);
        chk("R8 no abort", abort_cnt, 0);
        half_duplex_i = 1'b1;
    endtask

    initial begin
        t_reset();
        t_no_carrier();
        t_clean();
        t_loss();
        t_disable();
        t_full_duplex();
        t_no_carrier();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule